// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Clock

This block is a real-time clock with a small register port. It keeps a 32-bit count of seconds. A one-cycle crystal enable arrives in the bus clock domain, and a prescaler counts those enables. The prescaler raises a seconds tick once per calibrated period. A 21-bit calibration word sets the period. Its low half gives the whole number of crystal cycles per second. Its top five bits spread extra crystal cycles over a sixteen-second cycle, which trims the long-term rate of a crystal that runs slightly fast or slow.

Software writes a new time to the set register. That value waits as a pending load and moves into the current-time register only on the next tick. Until then, software can read the written value back from a second register. A sticky seconds flag shows whether a tick has happened since software last cleared the flag. Software can therefore tell which of the two registers holds the valid time. A calibration write restarts the prescaler, so the next tick comes exactly one calibrated period later. The interrupt output is the seconds flag gated by an enable bit. A battery-select bit is kept in the control register so that software can set it and read it back.

The bus port is a one-cycle write strobe with address and data. The read data is a combinational function of the address. Addresses are byte offsets, and the whole address is decoded.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the calibration register (offset 0x08, bits [20:0]) reads 0x198233. Offsets 0x04, 0x10, 0x20 and 0x40 read zero, and irq is low.
- R2: A write to offset 0x00 does not change offset 0x10 before the next tick. Offset 0x04 reads back the last value written to 0x00. Offset 0x00 itself reads zero.
- R3: On a tick with a load pending, offset 0x10 takes the last value written to 0x00 and the pending load clears. Later ticks increment the value instead of loading it again. If 0x00 is written twice before a tick, the second value wins.
- R4: On a tick with no load pending, offset 0x10 increments by one, modulo 2^32 (0xFFFFFFFF is followed by 0).
- R5: With calibration bits [20:16] equal to zero, a tick occurs once every W+1 crystal enables, where W is calibration bits [15:0].
- R6: Seconds are numbered k = 0..15 from the last calibration write, and the numbering wraps after 15. With calibration bits [20:16] = F, second k lasts W+2 enables when k < F and W+1 enables otherwise.
- R7: A write to offset 0x08 clears the prescaler and the second index. The next tick comes on exactly the W+1 (or W+2) enable after the write, whatever count the prescaler held before.
- R8: Offset 0x20 bit 0 is set by each tick and stays set. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A tick in the same cycle as a clear leaves the bit set.
- R9: Offset 0x40 bit 31 (battery select) and bit 0 (interrupt enable) are read/write. The other bits of 0x40 read zero. irq is high exactly when 0x20 bit 0 and 0x40 bit 0 are both set.
- R10: Reads of any offset not listed above return zero. Writes to 0x04 and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_en | input | 1 | One-cycle crystal enable, at most one per crystal cycle |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Seconds interrupt, the flag ANDed with the interrupt enable |

## Verification
The assertions take the crystal enable to be a clean single-cycle pulse. They also take a calibration write to restart counting. From these, the prescaler count can never pass its current limit, and every tick advances the second index by one. The bench always spaces enables at least two bus cycles apart. It picks random calibration values only with a small whole part, which keeps the prescaler range short enough to measure each second by counting pulses. It also drives the one coincidence that the priority rules name: a tick and a status clear in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int WHOLE_W = 16;
  localparam int FRAC_W  = 5;
  localparam int CAL_W   = WHOLE_W + FRAC_W;
  localparam int PHASE_W = 4;

  localparam logic [ADDR_W-1:0] OFS_SET_WR = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SET_RD = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CAL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_NOW    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h40;

  localparam logic [CAL_W-1:0] CAL_RESET = 21'h198233;
  localparam int CTRL_BATT_BIT = 31;
  localparam int CTRL_IE_BIT   = 0;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int WHOLE_W = rtc_pkg::WHOLE_W,
  parameter int FRAC_W  = rtc_pkg::FRAC_W,
  parameter int PHASE_W = rtc_pkg::PHASE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xtal_en,
  input  logic                       restart,
  input  logic [WHOLE_W+FRAC_W-1:0]  cal,
  output logic                       tick
);
  localparam int CNT_W = WHOLE_W + 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0]   limit;
  logic               stretch;
  logic               at_end;

  // Extra crystal cycle while the second index is below the fraction field.
  assign stretch = ({{(FRAC_W-PHASE_W){1'b0}}, phase_q} < cal[WHOLE_W+FRAC_W-1:WHOLE_W]);
  assign limit   = {1'b0, cal[WHOLE_W-1:0]} + {{(CNT_W-1){1'b0}}, stretch};
  assign at_end  = (cnt_q >= limit);
  assign tick    = xtal_en & ~restart & at_end;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (restart) begin
      cnt_d   = '0;
      phase_d = '0;
    end else if (xtal_en) begin
      if (at_end) begin
        cnt_d   = '0;
        phase_d = phase_q + 1'b1;
      end else begin
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_q == $past(phase_q) + 1'b1);

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && (phase_q == '0));
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep #(
  parameter int DATA_W = rtc_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              set_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] set_val,
  output logic [DATA_W-1:0] now_val
);
  logic [DATA_W-1:0] set_q, set_d;
  logic [DATA_W-1:0] now_q, now_d;
  logic              pend_q, pend_d;

  always_comb begin
    set_d  = set_q;
    now_d  = now_q;
    pend_d = pend_q;
    if (tick) begin
      if (pend_q) begin
        now_d  = set_q;
        pend_d = 1'b0;
      end else begin
        now_d  = now_q + 1'b1;
      end
    end
    if (set_wr) begin
      set_d  = wdata;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      now_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      set_q  <= set_d;
      now_q  <= now_d;
      pend_q <= pend_d;
    end
  end

  assign set_val = set_q;
  assign now_val = now_q;

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pend_q && !set_wr |=> (now_q == $past(set_q)) && !pend_q);

  // R4
  incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !pend_q |=> now_q == $past(now_q) + 1'b1);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(now_q));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs #(
  parameter int ADDR_W = rtc_pkg::ADDR_W,
  parameter int DATA_W = rtc_pkg::DATA_W,
  parameter int CAL_W  = rtc_pkg::CAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tick,
  input  logic [DATA_W-1:0] set_val,
  input  logic [DATA_W-1:0] now_val,
  output logic              set_wr,
  output logic              cal_wr,
  output logic [CAL_W-1:0]  cal,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rtc_pkg::*;

  logic [CAL_W-1:0] cal_q, cal_d;
  logic             batt_q, batt_d;
  logic             ie_q, ie_d;
  logic             flag_q, flag_d;
  logic             stat_wr, ctrl_wr;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[CTRL_BATT_BIT-1:CAL_W];

  assign set_wr  = bus_wr & (bus_addr == OFS_SET_WR);
  assign cal_wr  = bus_wr & (bus_addr == OFS_CAL);
  assign stat_wr = bus_wr & (bus_addr == OFS_STAT);
  assign ctrl_wr = bus_wr & (bus_addr == OFS_CTRL);

  always_comb begin
    cal_d  = cal_q;
    batt_d = batt_q;
    ie_d   = ie_q;
    flag_d = flag_q;
    if (cal_wr) cal_d = bus_wdata[CAL_W-1:0];
    if (ctrl_wr) begin
      batt_d = bus_wdata[CTRL_BATT_BIT];
      ie_d   = bus_wdata[CTRL_IE_BIT];
    end
    if (stat_wr && bus_wdata[0]) flag_d = 1'b0;
    if (tick) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= CAL_RESET;
      batt_q <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cal_q  <= cal_d;
      batt_q <= batt_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_SET_RD: bus_rdata = set_val;
      OFS_CAL:    bus_rdata = {{(DATA_W-CAL_W){1'b0}}, cal_q};
      OFS_NOW:    bus_rdata = now_val;
      OFS_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      OFS_CTRL: begin
        bus_rdata[CTRL_BATT_BIT] = batt_q;
        bus_rdata[CTRL_IE_BIT]   = ie_q;
      end
      default:    bus_rdata = '0;
    endcase
  end

  assign cal = cal_q;
  assign irq = flag_q & ie_q;

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag_q);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !stat_wr |=> flag_q);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int ADDR_W  = rtc_pkg::ADDR_W,
  parameter int DATA_W  = rtc_pkg::DATA_W,
  parameter int WHOLE_W = rtc_pkg::WHOLE_W,
  parameter int FRAC_W  = rtc_pkg::FRAC_W,
  parameter int PHASE_W = rtc_pkg::PHASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CAL_W = WHOLE_W + FRAC_W;

  logic              rst_sn;
  logic              tick;
  logic              set_wr;
  logic              cal_wr;
  logic [CAL_W-1:0]  cal;
  logic [DATA_W-1:0] set_val;
  logic [DATA_W-1:0] now_val;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rtc_prescaler #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sn),
    .xtal_en (xtal_en),
    .restart (cal_wr),
    .cal     (cal),
    .tick    (tick)
  );

  rtc_timekeep #(.DATA_W(DATA_W)) u_time (
    .clk     (clk),
    .rst_n   (rst_sn),
    .tick    (tick),
    .set_wr  (set_wr),
    .wdata   (bus_wdata),
    .set_val (set_val),
    .now_val (now_val)
  );

  rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAL_W(CAL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick      (tick),
    .set_val   (set_val),
    .now_val   (now_val),
    .set_wr    (set_wr),
    .cal_wr    (cal_wr),
    .cal       (cal),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );
endmodule

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xtal_en;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int exp_period(logic [20:0] c, int k);
    int w, f;
    w = int'(c[15:0]);
    f = int'(c[20:16]);
    return w + 1 + (((k % 16) < f) ? 1 : 0);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xtal_en = 1'b1;
      @(negedge clk); xtal_en = 1'b0;
    end
  endtask

  task automatic measure(output int n);
    logic [31:0] s;
    n = 0;
    do begin
      pulse(1);
      n++;
      rd(8'h20, s);
    end while (s[0] == 1'b0 && n < 200);
    wr(8'h20, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] sv;
    logic [20:0] c;
    int n, sum;
    v = $urandom(32'h5EED_0042);
    rst_n = 1'b0; xtal_en = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h08, v); check("R1 cal", v, 32'h0019_8233);
    rd(8'h04, v); check("R1 setrd", v, 0);
    rd(8'h10, v); check("R1 now", v, 0);
    rd(8'h20, v); check("R1 stat", v, 0);
    rd(8'h40, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'h0, irq}, 0);

    // R10 unmapped and R9 control
    rd(8'h0C, v); check("R10 unmapped", v, 0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R9 ctrl mask", v, 32'h8000_0001);
    wr(8'h40, 32'h8000_0000);
    rd(8'h40, v); check("R9 batt only", v, 32'h8000_0000);
    wr(8'h40, 32'h0000_0001);

    // R5 whole period W=3
    wr(8'h08, 32'h0000_0003);
    wr(8'h20, 32'h1);
    measure(n); check("R5 period a", n, 4);
    measure(n); check("R5 period b", n, 4);

    // R2 pending load not yet visible
    rd(8'h10, sv);
    wr(8'h00, 32'd100);
    rd(8'h04, v); check("R2 readback", v, 32'd100);
    rd(8'h00, v); check("R2 setwr reads 0", v, 0);
    rd(8'h10, v); check("R2 now held", v, sv);
    pulse(3);
    rd(8'h10, v); check("R2 now before tick", v, sv);
    rd(8'h20, v); check("R8 no flag yet", v, 0);
    pulse(1);
    rd(8'h10, v); check("R3 loaded", v, 32'd100);
    rd(8'h20, v); check("R8 flag set", v, 1);
    check("R9 irq high", {31'h0, irq}, 1);

    // R8 write 0 keeps flag, write 1 clears
    wr(8'h20, 32'h0);
    rd(8'h20, v); check("R8 write0 ignored", v, 1);
    wr(8'h20, 32'h1);
    rd(8'h20, v); check("R8 cleared", v, 0);
    check("R9 irq low", {31'h0, irq}, 0);

    // R3 increments after the load
    pulse(4);
    rd(8'h10, v); check("R3 incr after load", v, 32'd101);

    // R10 writes to readback and current time ignored
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h04, 32'hCAFE_0000);
    rd(8'h10, v); check("R10 now write ignored", v, 32'd101);
    rd(8'h04, v); check("R10 setrd write ignored", v, 32'd100);

    // R3 last write wins
    wr(8'h00, 32'd5);
    wr(8'h00, 32'd7);
    pulse(4);
    rd(8'h10, v); check("R3 last wins", v, 32'd7);

    // R4 wrap
    wr(8'h00, 32'hFFFF_FFFF);
    pulse(4);
    rd(8'h10, v); check("R4 load max", v, 32'hFFFF_FFFF);
    pulse(4);
    rd(8'h10, v); check("R4 wrap", v, 0);

    // R8 tick coincident with clear keeps flag
    wr(8'h20, 32'h1);
    wr(8'h08, 32'h0000_0003);
    pulse(3);
    @(negedge clk);
    xtal_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
    @(negedge clk);
    xtal_en = 1'b0; bus_wr = 1'b0;
    rd(8'h20, v); check("R8 tick beats clear", v, 1);
    wr(8'h20, 32'h1);

    // R7 restart mid count
    pulse(2);
    wr(8'h08, 32'h0000_0003);
    measure(n); check("R7 restart full period", n, 4);

    // R6 fractional, 17 seconds
    c = 21'h020003;
    wr(8'h08, {11'h0, c});
    wr(8'h20, 32'h1);
    sum = 0;
    for (int k = 0; k < 17; k++) begin
      measure(n);
      sum += n;
      if (k < 3 || k == 16) check("R6 frac second", n, exp_period(c, k));
    end
    check("R6 frac total", sum, 16 * 4 + 2 + 5);

    // Random calibration and set values (R5 R6 R7 R3)
    for (int it = 0; it < 10; it++) begin
      c = {5'($urandom_range(0, 31)), 16'($urandom_range(0, 6))};
      pulse($urandom_range(0, 3));
      wr(8'h08, {11'h0, c});
      wr(8'h20, 32'h1);
      sv = $urandom;
      wr(8'h00, sv);
      for (int k = 0; k < 3; k++) begin
        measure(n);
        check("R6 random period", n, exp_period(c, k));
      end
      rd(8'h10, v); check("R3 random load", v, sv + 32'd2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule